// File: doc/BRIEF.md
# Prioritized Graphics Buffer DMA Sequencer

This block shares one DMA data path among four buffer ports of a graphics engine: the output buffer, the blitter result buffer and the two blitter input buffers (B and A). Each port keeps its own configuration: transfer mode, item size, line width in pixels, buffer alignment, start offset and items per operand. A request on a port with a legal DMA configuration starts a line transfer. The line is moved as a series of operand bursts of one word per cycle, starting at word zero of the buffer. A fixed priority decides which port owns the path at each operand boundary.

Configurations are checked when a request arrives. An illegal request never enters arbitration and sets a sticky error bit for its port. Software clears that bit by writing one to it. A port in CPU mode ignores requests. A port whose transfer is running refuses all configuration writes, and an attempt to switch it to CPU mode at that point also raises its error bit.

Top module: `gfx_buf_dma_seq`

## Requirements
- R1: Port vector bit 0 is the output buffer, bit 1 the blit result buffer, bit 2 blit input B and bit 3 blit input A. When several ports wait at an operand boundary, the lowest set bit wins. `grant` is one-hot or zero.
- R2: A grant lasts exactly `opi` beat cycles, one operand, and is never split. The path is then idle for one cycle before it arbitrates again. A port that requests in cycle 0 has its first grant in cycle 2.
- R3: Mode code 2'b11 selects CPU transfer. In that mode a request gives no grant and no error. Reset puts every port in CPU mode.
- R4: A configuration write to a port whose transfer is active is ignored completely, and the transfer finishes with its original geometry. If that write carries mode 2'b11, the port's error bit is set.
- R5: Select codes 0 to 3 address ports 0 to 3. Code 4 writes the same configuration into both blit input ports (bits 2 and 3) in a single write.
- R6: With 32-bit items (`cfg_size32`=1), an alignment field `cfg_align` other than 0 makes a request illegal.
- R7: With 32-bit items an odd pixel width is illegal. With 16-bit items an odd width is legal.
- R8: Words per line equal the width at 16-bit size and half the width at 32-bit size. Items per operand must be a power of two from 1 to MAX_OPI. The words must divide evenly by the items per operand, and the line takes words/opi operands. So 480 pixels at 32 bits is rejected with 32 items and completes in 15 operands with 16 items.
- R9: A nonzero start offset `cfg_ofs` makes a request illegal. An illegal request sets the error bit one cycle after it is presented and is never granted.
- R10: `beat_addr` steps through 0 up to words-1 over the beats of a line. `done` for the port pulses high for exactly one cycle, in the cycle after the last beat, that is cycle 1+ops*(opi+1) after the request.
- R11: Error bits are sticky. Writing one to the matching `err_clr` bit clears the error in the next cycle, unless a new error arrives in that same cycle.
- R12: After reset, `grant`, `beat`, `done` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0..3 a single port, 4 both input ports |
| cfg_mode | input | 2 | Transfer mode, 2'b11 = CPU |
| cfg_size32 | input | 1 | 1 = 32-bit items, 0 = 16-bit items |
| cfg_align | input | 2 | Low two address bits of the first pixel |
| cfg_ofs | input | OFS_W | Start offset from the buffer base |
| cfg_width | input | WID_W | Line width in pixels |
| cfg_opi | input | OPI_W | Items per operand |
| err_clr | input | 4 | Write-one-to-clear for the error bits |
| req | input | 4 | Transfer request per port |
| grant | output | 4 | Port that owns the data path |
| beat | output | 1 | One word is moved this cycle |
| beat_addr | output | WID_W | Word index of the current beat within the buffer |
| done | output | 4 | One-cycle end-of-line pulse per port |
| err | output | 4 | Sticky per-port error |

## Verification
A request is seen at the first clock edge, so the first grant appears at the second edge, and the port's error bit rises at the first edge if the configuration is illegal. Every operand then takes opi beats plus one idle cycle, so `done` is due exactly 1+ops*(opi+1) edges after the request. The bench drives inputs and samples outputs on the falling edge. For each line it counts edges from the request, checks that `done` arrives in precisely the computed cycle, and checks `beat_addr` against the running beat count. The priority scenario records the order in which grants start and compares it with the sequence the fixed order and the operand boundaries predict.

// File: rtl/gbd_pkg.sv
package gbd_pkg;
   localparam int unsigned NPORT = 4;
   localparam logic [1:0] MODE_CPU = 2'b11;
   localparam logic [1:0] MODE_DMA = 2'b00;

   typedef enum logic [2:0] {
      SEL_OUT    = 3'd0,
      SEL_RES    = 3'd1,
      SEL_INB    = 3'd2,
      SEL_INA    = 3'd3,
      SEL_INPAIR = 3'd4
   } gbd_sel_e;
endpackage

// File: rtl/gbd_port_ctl.sv
module gbd_port_ctl
   import gbd_pkg::*;
#(
   parameter int unsigned IDX     = 0,
   parameter int unsigned WID_W   = 10,
   parameter int unsigned OPI_W   = 6,
   parameter int unsigned OFS_W   = 8,
   parameter int unsigned MAX_OPI = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_size32,
   input  logic [1:0]       cfg_align,
   input  logic [OFS_W-1:0] cfg_ofs,
   input  logic [WID_W-1:0] cfg_width,
   input  logic [OPI_W-1:0] cfg_opi,
   input  logic             err_clr,
   input  logic             req,
   input  logic             beat,
   input  logic             op_end,
   output logic             active,
   output logic             done,
   output logic             err,
   output logic [WID_W-1:0] wpos,
   output logic [OPI_W-1:0] opi
);
   localparam logic [2:0] MY_SEL = 3'(IDX);
   localparam bit IS_INPUT = (IDX >= 2);
   localparam logic [OPI_W-1:0] OPI_LIM = OPI_W'(MAX_OPI);

   logic [1:0]       mode_q;
   logic             size32_q;
   logic [1:0]       align_q;
   logic [OFS_W-1:0] ofs_q;
   logic [WID_W-1:0] width_q;
   logic [WID_W-1:0] ops_left;

   logic             hit;
   logic             mode_cpu;
   logic [WID_W-1:0] words;
   logic [WID_W-1:0] opi_ext;
   logic [WID_W-1:0] ops_total;
   logic             opi_ok;
   logic             cfg_ok;
   logic             start;
   logic             lock_bad;
   logic             err_set;

   assign opi = opi_q;
   logic [OPI_W-1:0] opi_q;

   always_comb begin
      hit = 1'b0;
      if (cfg_we) begin
         if (cfg_sel == MY_SEL) hit = 1'b1;
         if (IS_INPUT && cfg_sel == SEL_INPAIR) hit = 1'b1;
      end
   end

   always_comb begin
      mode_cpu  = (mode_q == MODE_CPU);
      words     = size32_q ? (width_q >> 1) : width_q;
      opi_ext   = WID_W'(opi_q);
      opi_ok    = (opi_q != '0) && ((opi_q & (opi_q - 1'b1)) == '0) && (opi_q <= OPI_LIM);
      ops_total = words;
      for (int i = 0; i < OPI_W; i++) begin
         if (opi_q[i]) ops_total = words >> i;
      end
      cfg_ok = opi_ok && (width_q != '0) && (words != '0)
             && !(size32_q && (align_q != 2'b00))
             && !(size32_q && width_q[0])
             && (ofs_q == '0)
             && ((words & (opi_ext - 1'b1)) == '0);
      start    = req && !active && !mode_cpu;
      lock_bad = hit && active && (cfg_mode == MODE_CPU);
      err_set  = (start && !cfg_ok) || lock_bad;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_CPU;
         size32_q <= 1'b0;
         align_q  <= '0;
         ofs_q    <= '0;
         width_q  <= '0;
         opi_q    <= '0;
      end else if (hit && !active) begin
         mode_q   <= cfg_mode;
         size32_q <= cfg_size32;
         align_q  <= cfg_align;
         ofs_q    <= cfg_ofs;
         width_q  <= cfg_width;
         opi_q    <= cfg_opi;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         done     <= 1'b0;
         ops_left <= '0;
         wpos     <= '0;
      end else begin
         done <= 1'b0;
         if (start && cfg_ok) begin
            active   <= 1'b1;
            ops_left <= ops_total;
            wpos     <= '0;
         end else if (active) begin
            if (beat) wpos <= wpos + 1'b1;
            if (op_end) begin
               ops_left <= ops_left - 1'b1;
               if (ops_left == WID_W'(1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         err <= 1'b0;
      else if (err_set)   err <= 1'b1;
      else if (err_clr)   err <= 1'b0;
   end

   // R3
   cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_cpu |-> !active);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !active);
   // R11
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !err_set) |=> !err);
   // R4
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && active) |=> ($stable(width_q) && $stable(mode_q) && $stable(opi_q)));
endmodule

// File: rtl/gbd_prio_arb.sv
module gbd_prio_arb #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);
   for (genvar i = 0; i < N; i++) begin : g_lane
      if (i == 0) begin : g_top
         assign pick[i] = req[i];
      end else begin : g_rest
         assign pick[i] = req[i] && !(|req[i-1:0]);
      end
   end

   // R1
   always_comb begin
      pick_onehot_chk: assert ($onehot0(pick));
   end
endmodule

// File: rtl/gbd_burst_eng.sv
module gbd_burst_eng #(
   parameter int unsigned N     = 4,
   parameter int unsigned OPI_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     act,
   input  logic [N-1:0]     pick,
   input  logic [OPI_W-1:0] opi_a [N],
   output logic [N-1:0]     gnt,
   output logic [N-1:0]     op_end,
   output logic             beat
);
   logic [OPI_W-1:0] cnt;
   logic [OPI_W-1:0] opi_sel;

   always_comb begin
      opi_sel = '0;
      for (int i = 0; i < N; i++) begin
         if (pick[i]) opi_sel = opi_sel | opi_a[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt <= '0;
         cnt <= '0;
      end else if (gnt == '0) begin
         if (|pick) begin
            gnt <= pick;
            cnt <= opi_sel - 1'b1;
         end
      end else if (cnt == '0) begin
         gnt <= '0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign op_end = (cnt == '0) ? gnt : '0;
   assign beat   = |gnt;

   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   // R2
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && cnt != '0) |=> $stable(gnt));
   // R2
   grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && cnt == '0) |=> (gnt == '0));
   // R2
   grant_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~act) == '0);
endmodule

// File: rtl/gfx_buf_dma_seq.sv
module gfx_buf_dma_seq
   import gbd_pkg::*;
#(
   parameter int unsigned WID_W   = 10,
   parameter int unsigned OPI_W   = 6,
   parameter int unsigned OFS_W   = 8,
   parameter int unsigned MAX_OPI = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_size32,
   input  logic [1:0]       cfg_align,
   input  logic [OFS_W-1:0] cfg_ofs,
   input  logic [WID_W-1:0] cfg_width,
   input  logic [OPI_W-1:0] cfg_opi,
   input  logic [3:0]       err_clr,
   input  logic [3:0]       req,
   output logic [3:0]       grant,
   output logic             beat,
   output logic [WID_W-1:0] beat_addr,
   output logic [3:0]       done,
   output logic [3:0]       err
);
   localparam int unsigned NP = NPORT;

   if (WID_W < OPI_W) begin : g_bad_wid
      $error("WID_W must be at least OPI_W");
   end
   if (MAX_OPI < 1 || MAX_OPI > (1 << (OPI_W - 1))) begin : g_bad_opi
      $error("MAX_OPI out of range for OPI_W");
   end

   logic [NP-1:0]    act;
   logic [NP-1:0]    pick;
   logic [NP-1:0]    op_end;
   logic [WID_W-1:0] wpos_a [NP];
   logic [OPI_W-1:0] opi_a  [NP];

   for (genvar p = 0; p < NP; p++) begin : g_port
      gbd_port_ctl #(
         .IDX(p), .WID_W(WID_W), .OPI_W(OPI_W), .OFS_W(OFS_W), .MAX_OPI(MAX_OPI)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_we),
         .cfg_sel   (cfg_sel),
         .cfg_mode  (cfg_mode),
         .cfg_size32(cfg_size32),
         .cfg_align (cfg_align),
         .cfg_ofs   (cfg_ofs),
         .cfg_width (cfg_width),
         .cfg_opi   (cfg_opi),
         .err_clr   (err_clr[p]),
         .req       (req[p]),
         .beat      (grant[p]),
         .op_end    (op_end[p]),
         .active    (act[p]),
         .done      (done[p]),
         .err       (err[p]),
         .wpos      (wpos_a[p]),
         .opi       (opi_a[p])
      );
   end

   gbd_prio_arb #(.N(NP)) u_arb (
      .req (act),
      .pick(pick)
   );

   gbd_burst_eng #(.N(NP), .OPI_W(OPI_W)) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .pick  (pick),
      .opi_a (opi_a),
      .gnt   (grant),
      .op_end(op_end),
      .beat  (beat)
   );

   always_comb begin
      beat_addr = '0;
      for (int i = 0; i < NP; i++) begin
         if (grant[i]) beat_addr = beat_addr | wpos_a[i];
      end
   end

   // R10
   done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done != '0) |-> $past(grant != '0));
endmodule

// File: tb/sim_gfx_buf_dma_seq.sv
`timescale 1ns/1ps
module sim_gfx_buf_dma_seq;
   localparam int WID_W = 10;
   localparam int OPI_W = 6;
   localparam int OFS_W = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_we;
   logic [2:0]       cfg_sel;
   logic [1:0]       cfg_mode;
   logic             cfg_size32;
   logic [1:0]       cfg_align;
   logic [OFS_W-1:0] cfg_ofs;
   logic [WID_W-1:0] cfg_width;
   logic [OPI_W-1:0] cfg_opi;
   logic [3:0]       err_clr;
   logic [3:0]       req;
   logic [3:0]       grant;
   logic             beat;
   logic [WID_W-1:0] beat_addr;
   logic [3:0]       done;
   logic [3:0]       err;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   gfx_buf_dma_seq u0 (.*);

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic cfg(input int sel, input int mode, input int s32, input int al,
                      input int ofs, input int width, input int opi);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_mode = 2'(mode); cfg_size32 = 1'(s32);
      cfg_align = 2'(al); cfg_ofs = OFS_W'(ofs); cfg_width = WID_W'(width); cfg_opi = OPI_W'(opi);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_err(input int p);
      @(negedge clk);
      err_clr = 4'b0001 << p;
      @(negedge clk);
      err_clr = 4'b0000;
   endtask

   // legal line: done exactly at cycle 1+ops*(opi+1), beat_addr 0..words-1
   task automatic run_line(input int p, input int words, input int opi, input string rq);
      int ops, beats, cyc, got_done, addr_bad;
      ops = words / opi; beats = 0; got_done = 0; addr_bad = 0; cyc = 0;
      @(negedge clk);
      req = 4'b0001 << p;
      for (int c = 1; c < 5000; c++) begin
         @(negedge clk);
         req = 4'b0000;
         if (grant[p]) begin
            if (int'(beat_addr) != beats) addr_bad++;
            beats++;
         end
         if (done[p]) begin got_done = 1; cyc = c; break; end
      end
      chk(got_done == 1 && cyc == 1 + ops * (opi + 1), {rq, " R10 done cycle"}, cyc, 1 + ops * (opi + 1));
      chk(beats == words, {rq, " R8 beat count"}, beats, words);
      chk(addr_bad == 0, {rq, " R10 beat_addr sequence"}, addr_bad, 0);
      @(negedge clk);
      chk(done[p] == 1'b0, {rq, " R10 done single cycle"}, int'(done[p]), 0);
      chk(err[p] == 1'b0, {rq, " R8 no error on legal line"}, int'(err[p]), 0);
   endtask

   // illegal request: error next cycle, never granted
   task automatic reject(input int p, input string rq);
      int granted;
      granted = 0;
      @(negedge clk);
      req = 4'b0001 << p;
      @(negedge clk);
      req = 4'b0000;
      chk(err[p] == 1'b1, {rq, " error raised"}, int'(err[p]), 1);
      for (int c = 0; c < 6; c++) begin
         if (grant[p]) granted++;
         @(negedge clk);
      end
      chk(granted == 0, {rq, " no grant"}, granted, 0);
      clear_err(p);
      chk(err[p] == 1'b0, "R11 write-one clear", int'(err[p]), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_mode = 0; cfg_size32 = 0; cfg_align = 0;
      cfg_ofs = 0; cfg_width = 0; cfg_opi = 0; err_clr = 0; req = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(grant == 4'b0 && beat == 1'b0, "R12 grant/beat idle", int'(grant), 0);
      chk(done == 4'b0 && err == 4'b0, "R12 done/err clear", int'({done, err}), 0);
   endtask

   task automatic t_cpu_mode();
      int granted;
      granted = 0;
      // port 1 still in reset CPU mode
      @(negedge clk); req = 4'b0010;
      @(negedge clk); req = 4'b0000;
      for (int c = 0; c < 5; c++) begin
         if (grant != 0) granted++;
         @(negedge clk);
      end
      chk(granted == 0, "R3 reset CPU mode gives no grant", granted, 0);
      cfg(1, 3, 0, 0, 0, 8, 4);
      @(negedge clk); req = 4'b0010;
      @(negedge clk); req = 4'b0000;
      for (int c = 0; c < 5; c++) begin
         if (grant != 0) granted++;
         @(negedge clk);
      end
      chk(granted == 0, "R3 CPU mode gives no grant", granted, 0);
      chk(err[1] == 1'b0, "R3 CPU mode gives no error", int'(err[1]), 0);
   endtask

   task automatic t_basic();
      cfg(0, 0, 0, 0, 0, 8, 4);
      run_line(0, 8, 4, "R2 16-bit 8px opi4");
      cfg(1, 0, 0, 0, 0, 7, 1);
      run_line(1, 7, 1, "R7 16-bit odd width");
   endtask

   task automatic t_full_line();
      cfg(1, 0, 1, 0, 0, 480, 16);
      run_line(1, 240, 16, "R8 480px 32-bit opi16");
      cfg(1, 0, 1, 0, 0, 480, 32);
      reject(1, "R8 480px 32-bit opi32");
      cfg(1, 0, 0, 0, 0, 12, 3);
      reject(1, "R8 non power-of-two opi");
   endtask

   task automatic t_rules();
      cfg(0, 0, 1, 2'b10, 0, 16, 4);
      reject(0, "R6 32-bit misaligned");
      cfg(0, 0, 0, 2'b10, 0, 16, 4);
      run_line(0, 16, 4, "R6 16-bit misaligned legal");
      cfg(0, 0, 1, 0, 0, 15, 1);
      reject(0, "R7 32-bit odd width");
      cfg(0, 0, 0, 0, 4, 16, 4);
      reject(0, "R9 nonzero start offset");
   endtask

   task automatic t_pair();
      cfg(4, 0, 1, 0, 0, 16, 2);
      run_line(2, 8, 2, "R5 shared write input B");
      run_line(3, 8, 2, "R5 shared write input A");
   endtask

   task automatic t_priority();
      int seq[8];
      int n, prev;
      cfg(0, 0, 0, 0, 0, 2, 1);
      cfg(1, 0, 0, 0, 0, 2, 1);
      cfg(4, 0, 0, 0, 0, 2, 1);
      n = 0; prev = 0;
      @(negedge clk); req = 4'b1111;
      for (int c = 0; c < 60 && n < 8; c++) begin
         @(negedge clk);
         req = 4'b0000;
         if (grant != 0 && prev == 0) begin
            for (int i = 0; i < 4; i++) if (grant[i]) seq[n] = i;
            n++;
         end
         prev = int'(grant);
      end
      chk(n == 8, "R1 grant count", n, 8);
      for (int k = 0; k < 8; k++)
         chk(seq[k] == k / 2, "R1 fixed priority order", seq[k], k / 2);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_lock();
      int beats, got_done;
      beats = 0; got_done = 0;
      cfg(3, 0, 0, 0, 0, 64, 4);
      @(negedge clk); req = 4'b1000;
      @(negedge clk); req = 4'b0000;
      if (grant[3]) beats++;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (grant[3]) beats++;
      end
      cfg_we = 1'b1; cfg_sel = 3'd3; cfg_mode = 2'b11; cfg_width = 10'd2; cfg_opi = 6'd1;
      @(negedge clk);
      cfg_we = 1'b0;
      if (grant[3]) beats++;
      chk(err[3] == 1'b1, "R4 CPU switch mid-transfer flags error", int'(err[3]), 1);
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (grant[3]) beats++;
         if (done[3]) begin got_done = 1; break; end
      end
      chk(got_done == 1 && beats == 64, "R4 transfer kept original geometry", beats, 64);
      chk(err[3] == 1'b1, "R11 error sticky", int'(err[3]), 1);
      clear_err(3);
      chk(err[3] == 1'b0, "R11 write-one clear", int'(err[3]), 0);
      run_line(3, 64, 4, "R4 mode write was ignored");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_cpu_mode();
      t_basic();
      t_full_line();
      t_rules();
      t_pair();
      t_priority();
      t_lock();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule